// File: doc/BRIEF.md
# Aligned Memory Signature Scanner

This block is a small bus master that looks through a fixed physical address window for a four-byte marker. It only considers addresses that are multiples of 16 as possible positions for the marker. At each such position it reads bytes one at a time. It stops checking a position at the first byte that does not match, then moves on to the next 16-byte boundary. At the first position where all four marker bytes match, it reads the four bytes that follow the marker. It combines them as a little-endian 32-bit pointer and reports that pointer together with the address where the marker was found.

Software or a boot sequencer pulses `start` and then waits for `done`. When `done` is high, exactly one of `found` and `miss` is high. The result outputs keep their values until the next accepted `start`. Memory is reached through a byte read request channel and a byte response channel:

- **Request channel.** The request is a valid/ready pair. Once `rd_req_valid` is raised, it stays high with an unchanged `rd_req_addr` until the cycle in which `rd_req_ready` is also high. The memory side may hold ready low for any number of cycles to apply back-pressure.
- **Response channel.** The response has no ready signal. The scanner keeps at most one read outstanding and is always able to take the response to it.

Top module: `sig_scanner`

## Requirements
- R1: After reset, `busy`, `done`, `found`, `miss` and `rd_req_valid` are all low.
- R2: Every read address lies in 0xF0000..0xFFFFF and has a low nibble in 0..7. The first read after `start` is at 0xF0000. Positions are tried in increasing order, 16 bytes apart.
- R3: A position holds the marker when its bytes at offsets 0, 1, 2 and 3 are 0x5F, 0x4D, 0x50 and 0x5F ('_', 'M', 'P', '_'). The marker bytes are read in that order.
- R4: At a position, reading stops at the first marker byte that does not match, and the next read goes to offset 0 of the next position. A position whose first k bytes match therefore costs k+1 reads.
- R5: On a match, the bytes at offsets 4..7 are read and `table_ptr` is set to their little-endian value: offset 4 gives bits 7:0 and offset 7 gives bits 31:24. A successful scan costs exactly 8 reads at the matching position.
- R6: The scan ends at the first matching position. It sets `done` and `found`, and sets `match_addr` to that position's address. Later markers are never read.
- R7: If the last position (0xFFFF0) fails, the scan ends with `done` and `miss` high and `found` low.
- R8: While `rd_req_valid` is high and `rd_req_ready` is low, the request stays valid and `rd_req_addr` does not change.
- R9: A `start` pulse while `busy` is high has no effect on the scan in progress, its reads or its result.
- R10: `done`, `found`, `miss`, `match_addr` and `table_ptr` hold their values until the next `start`. That `start` clears `done`, `found` and `miss` one cycle later.
- R11: A marker that begins at an address not divisible by 16 is never reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a scan; accepted only while not busy |
| busy | output | 1 | A scan is in progress |
| done | output | 1 | The last scan has finished; result outputs are valid |
| found | output | 1 | The last scan found the marker |
| miss | output | 1 | The last scan reached the end of the window without a match |
| match_addr | output | 20 | Address of the position where the marker was found |
| table_ptr | output | 32 | Little-endian pointer read after the marker |
| rd_req_valid | output | 1 | Byte read request valid |
| rd_req_ready | input | 1 | Memory accepts the request this cycle |
| rd_req_addr | output | 20 | Byte address of the request |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 8 | Read data byte |

## Verification
The assertions rely on the memory side never returning a response unless a request has been accepted and is still unanswered. The bench's memory model raises `rd_rsp_valid` for exactly one cycle, in the cycle after each handshake, so it keeps to that rule even when it withholds `rd_req_ready` to stall requests. The bench asserts `start` during a scan only in cycles where the scanner cannot be finishing. This keeps the ignored-start check from meeting a scan that ends in the same cycle.

// File: rtl/sigscan_pkg.sv
package sigscan_pkg;

  localparam int SIG_BYTES = 4;
  localparam int PTR_BYTES = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } scan_state_e;

  // Marker bytes in increasing address order: '_' 'M' 'P' '_'
  function automatic logic [7:0] marker_byte(input int idx);
    case (idx)
      0:       return 8'h5F;
      1:       return 8'h4D;
      2:       return 8'h50;
      default: return 8'h5F;
    endcase
  endfunction

endpackage

// File: rtl/sigscan_cand_gen.sv
module sigscan_cand_gen #(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned WIN_BASE = 32'hF0000,
  parameter int unsigned WIN_END  = 32'hFFFFF,
  parameter int unsigned STRIDE   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  output logic [ADDR_W-1:0] cand_addr,
  output logic              cand_last
);

  localparam logic [ADDR_W-1:0] BASE_A    = ADDR_W'(WIN_BASE);
  localparam logic [ADDR_W-1:0] LAST_CAND = ADDR_W'(WIN_END - STRIDE + 1);
  localparam logic [ADDR_W-1:0] STEP      = ADDR_W'(STRIDE);

  logic [ADDR_W-1:0] cand_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cand_q <= BASE_A;
    else if (load)    cand_q <= BASE_A;
    else if (advance) cand_q <= cand_q + STEP;
  end

  assign cand_addr = cand_q;
  assign cand_last = (cand_q == LAST_CAND);

  AST_CAND_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_q >= BASE_A) && (cand_q <= LAST_CAND)); // R2
  AST_NO_STEP_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> !cand_last); // R7

endmodule

// File: rtl/sigscan_byte_cmp.sv
module sigscan_byte_cmp #(
  parameter int IDX_W = 2
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       data,
  output logic             hit
);
  import sigscan_pkg::*;

  localparam int N = 1 << IDX_W;

  logic [N-1:0] eq;

  for (genvar g = 0; g < N; g++) begin : g_eq
    assign eq[g] = (data == marker_byte(g));
  end

  assign hit = eq[idx];

endmodule

// File: rtl/sigscan_ptr_acc.sv
module sigscan_ptr_acc #(
  parameter int BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             shift,
  input  logic [7:0]       byte_in,
  output logic [8*BYTES-1:0] value
);

  logic [8*BYTES-1:0] acc_q;

  // Newest byte enters at the top; the first byte ends up in bits 7:0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc_q <= '0;
    else if (clear) acc_q <= '0;
    else if (shift) acc_q <= {byte_in, acc_q[8*BYTES-1:8]};
  end

  assign value = acc_q;

endmodule

// File: rtl/sig_scanner.sv
module sig_scanner #(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned WIN_BASE = 32'hF0000,
  parameter int unsigned WIN_END  = 32'hFFFFF,
  parameter int unsigned STRIDE   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              found,
  output logic              miss,
  output logic [ADDR_W-1:0] match_addr,
  output logic [31:0]       table_ptr,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [7:0]        rd_rsp_data
);
  import sigscan_pkg::*;

  localparam int TOTAL     = SIG_BYTES + PTR_BYTES;
  localparam int IDX_W     = $clog2(TOTAL);
  localparam int SIG_IDX_W = $clog2(SIG_BYTES);
  localparam int ALIGN_W   = $clog2(STRIDE);
  localparam logic [ADDR_W-1:0] BASE_A    = ADDR_W'(WIN_BASE);
  localparam logic [ADDR_W-1:0] LAST_CAND = ADDR_W'(WIN_END - STRIDE + 1);

  scan_state_e       st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              found_q, miss_q;
  logic [ADDR_W-1:0] match_q;

  logic              launch, rsp_take, in_sig, last_idx, byte_ok;
  logic              cand_load, cand_adv, ptr_shift, set_found, set_miss;
  logic [ADDR_W-1:0] cand_addr;
  logic              cand_last;
  logic [31:0]       ptr_val;

  sigscan_cand_gen #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_END(WIN_END), .STRIDE(STRIDE)
  ) u_cand (
    .clk(clk), .rst_n(rst_n), .load(cand_load), .advance(cand_adv),
    .cand_addr(cand_addr), .cand_last(cand_last)
  );

  sigscan_byte_cmp #(.IDX_W(SIG_IDX_W)) u_cmp (
    .idx(idx_q[SIG_IDX_W-1:0]), .data(rd_rsp_data), .hit(byte_ok)
  );

  sigscan_ptr_acc #(.BYTES(PTR_BYTES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .clear(launch), .shift(ptr_shift),
    .byte_in(rd_rsp_data), .value(ptr_val)
  );

  assign launch   = start && ((st_q == ST_IDLE) || (st_q == ST_DONE));
  assign rsp_take = (st_q == ST_WAIT) && rd_rsp_valid;
  assign in_sig   = (idx_q < IDX_W'(SIG_BYTES));
  assign last_idx = (idx_q == IDX_W'(TOTAL - 1));

  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    cand_load = 1'b0;
    cand_adv  = 1'b0;
    ptr_shift = 1'b0;
    set_found = 1'b0;
    set_miss  = 1'b0;
    case (st_q)
      ST_IDLE, ST_DONE: begin
        if (launch) begin
          st_d      = ST_REQ;
          idx_d     = '0;
          cand_load = 1'b1;
        end
      end
      ST_REQ: begin
        if (rd_req_ready) st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (rd_rsp_valid) begin
          if (!in_sig) begin
            ptr_shift = 1'b1;
            if (last_idx) begin
              st_d      = ST_DONE;
              set_found = 1'b1;
            end else begin
              st_d  = ST_REQ;
              idx_d = idx_q + IDX_W'(1);
            end
          end else if (byte_ok) begin
            st_d  = ST_REQ;
            idx_d = idx_q + IDX_W'(1);
          end else if (cand_last) begin
            st_d     = ST_DONE;
            set_miss = 1'b1;
          end else begin
            st_d     = ST_REQ;
            idx_d    = '0;
            cand_adv = 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      found_q <= 1'b0;
      miss_q  <= 1'b0;
      match_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      if (launch) begin
        found_q <= 1'b0;
        miss_q  <= 1'b0;
      end
      if (set_found) begin
        found_q <= 1'b1;
        match_q <= cand_addr;
      end
      if (set_miss) miss_q <= 1'b1;
    end
  end

  assign busy         = (st_q == ST_REQ) || (st_q == ST_WAIT);
  assign done         = (st_q == ST_DONE);
  assign found        = found_q;
  assign miss         = miss_q;
  assign match_addr   = match_q;
  assign table_ptr    = ptr_val;
  assign rd_req_valid = (st_q == ST_REQ);
  assign rd_req_addr  = cand_addr + ADDR_W'(idx_q);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr)); // R8
  AST_REQ_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (rd_req_addr >= BASE_A) && (rd_req_addr[ALIGN_W-1:0] < ALIGN_W'(TOTAL))); // R2
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !rd_rsp_valid |=> busy); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(found) && $stable(miss)
                       && $stable(match_addr) && $stable(table_ptr)); // R10
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (found != miss)); // R6
  AST_MATCH_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (match_addr[ALIGN_W-1:0] == '0) && (match_addr >= BASE_A)); // R11
  AST_MISS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miss) |-> ($past(rd_req_addr[ADDR_W-1:ALIGN_W]) == LAST_CAND[ADDR_W-1:ALIGN_W])); // R7

endmodule

// File: tb/sig_scanner_tb.sv
module sig_scanner_tb;

  typedef struct packed {
    logic [19:0] sig_a;
    logic        sig_on;
    logic [19:0] dec_a;
    logic [2:0]  dec_len;
    logic [31:0] ptr;
    logic        stall;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{20'hF0000, 1'b1, 20'h00000, 3'd0, 32'h000F1234, 1'b0},  // first position
    '{20'hFFFF0, 1'b1, 20'h00000, 3'd0, 32'h12345678, 1'b1},  // last position, stalls
    '{20'hF0080, 1'b1, 20'hF0040, 3'd3, 32'hDEADBEEF, 1'b0},  // 3-byte decoy first
    '{20'h00000, 1'b0, 20'hF8000, 3'd2, 32'h00000000, 1'b1},  // no marker
    '{20'hF0108, 1'b1, 20'h00000, 3'd0, 32'hCAFEF00D, 1'b0},  // misaligned marker
    '{20'hF2000, 1'b1, 20'hF1000, 3'd4, 32'hAAAA5555, 1'b0}   // two markers
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        busy, done, found, miss;
  logic [19:0] match_addr;
  logic [31:0] table_ptr;
  logic        rd_req_valid;
  logic        rd_req_ready = 1'b0;
  logic [19:0] rd_req_addr;
  logic        rd_rsp_valid = 1'b0;
  logic [7:0]  rd_rsp_data = 8'h00;

  int checks = 0;
  int errors = 0;

  vec_t cur;
  int   reads, bad_addr, hold_viol;
  logic acc_pend = 1'b0;
  logic [19:0] acc_addr;
  logic prev_stalled = 1'b0;
  logic [19:0] prev_addr;
  int   cyc = 0;

  bit   exp_found;
  logic [19:0] exp_addr;
  logic [31:0] exp_ptr;
  int   exp_reads;

  always #10 clk = ~clk;  // 50 MHz

  sig_scanner u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .found(found), .miss(miss), .match_addr(match_addr), .table_ptr(table_ptr),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data)
  );

  function automatic logic [7:0] mark(input int k);
    case (k)
      0: return 8'h5F;
      1: return 8'h4D;
      2: return 8'h50;
      default: return 8'h5F;
    endcase
  endfunction

  // Background bytes are 0x00..0x0F, never a marker byte
  function automatic logic [7:0] mem_rd(input logic [19:0] a);
    int unsigned aa = a;
    int unsigned da = cur.dec_a;
    int unsigned sa = cur.sig_a;
    logic [7:0] b = {4'h0, a[3:0]};
    if (cur.dec_len != 0 && aa >= da && aa < da + cur.dec_len) b = mark(int'(aa - da));
    if (cur.sig_on && aa >= sa && aa < sa + 4) b = mark(int'(aa - sa));
    else if (cur.sig_on && aa >= sa + 4 && aa < sa + 8) b = cur.ptr[8*(aa - sa - 4) +: 8];
    return b;
  endfunction

  // Reference from the requirements: probe aligned positions in order
  task automatic predict();
    exp_found = 0; exp_addr = '0; exp_ptr = '0; exp_reads = 0;
    for (int c = 0; c < 4096; c++) begin
      logic [19:0] p = 20'hF0000 + 20'(c * 16);
      int k = 0;
      while (k < 4) begin
        exp_reads++;
        if (mem_rd(p + 20'(k)) != mark(k)) break;
        k++;
      end
      if (k == 4) begin
        exp_found = 1; exp_addr = p; exp_reads += 4;
        for (int j = 0; j < 4; j++) exp_ptr[8*j +: 8] = mem_rd(p + 20'(4 + j));
        break;
      end
    end
  endtask

  // Memory model: driven away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      rd_rsp_valid = 1'b0;
      if (acc_pend) begin
        rd_rsp_valid = 1'b1;
        rd_rsp_data  = mem_rd(acc_addr);
        acc_pend     = 1'b0;
      end
      if (prev_stalled && (!rd_req_valid || rd_req_addr != prev_addr)) hold_viol++;
      rd_req_ready = !(cur.stall && (cyc % 3 == 0));
      prev_stalled = rd_req_valid && !rd_req_ready;
      prev_addr    = rd_req_addr;
      if (rd_req_valid && rd_req_ready) begin
        reads++;
        if (rd_req_addr < 20'hF0000 || rd_req_addr[3:0] > 4'd7) bad_addr++;
        acc_pend = 1'b1;
        acc_addr = rd_req_addr;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 40000) begin @(negedge clk); n++; end
  endtask

  task automatic check_result(input string tag);
    chk(done == 1'b1, {tag, " R6 done"}, done, 1);
    chk(found == exp_found, {tag, " R6/R7/R11 found"}, found, exp_found);
    chk(miss == !exp_found, {tag, " R7 miss"}, miss, !exp_found);
    if (exp_found) begin
      chk(match_addr == exp_addr, {tag, " R6 match_addr"}, match_addr, exp_addr);
      chk(table_ptr == exp_ptr, {tag, " R5 table_ptr"}, table_ptr, exp_ptr);
    end
    chk(reads == exp_reads, {tag, " R4/R3 read count"}, reads, exp_reads);
    chk(bad_addr == 0, {tag, " R2 address"}, bad_addr, 0);
    chk(hold_viol == 0, {tag, " R8 request hold"}, hold_viol, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cur = VECS[0];
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !found && !miss && !rd_req_valid, "R1 reset outputs",
        {busy, done, found, miss, rd_req_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !rd_req_valid, "R1 idle after reset",
        {busy, done, rd_req_valid}, 0);

    for (int v = 0; v < NV; v++) begin
      cur = VECS[v];
      predict();
      reads = 0; bad_addr = 0; hold_viol = 0;
      pulse_start();
      wait_done();
      check_result($sformatf("vec%0d", v));
    end

    // R9: start pulses in mid-scan are ignored (vector 2)
    cur = VECS[2];
    predict();
    reads = 0; bad_addr = 0; hold_viol = 0;
    pulse_start();
    repeat (25) begin
      @(negedge clk);
      start = !rd_rsp_valid && busy;
    end
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R9 still busy", busy, 1);
    wait_done();
    check_result("R9 restart ignored");

    // R10: results hold, then next start clears them
    repeat (40) @(negedge clk);
    chk(done && found && match_addr == exp_addr && table_ptr == exp_ptr,
        "R10 result hold", {done, found, match_addr}, {1'b1, 1'b1, exp_addr});
    cur = VECS[3];
    predict();
    reads = 0; bad_addr = 0; hold_viol = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(!done && !found && !miss && busy, "R10 start clears result",
        {done, found, miss, busy}, 4'b0001);
    wait_done();
    check_result("R10 rescan");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule